// File: doc/BRIEF.md
# Serial Peripheral Master with Cascaded Bit-Rate Divider

This block is a synchronous serial master. For each frame it sends a word out on MOSI, most significant bit first, and shifts MISO in at the same time. The system clock is first divided by an even prescale value and then by (1 + SCR) to produce the serial bit rate. The idle level of SCLK is selectable, and so is the edge that captures data. Together these give the four usual clock modes.

Software places a 32-bit control word, a prescale byte and a transmit word on the inputs, then pulses `start`. The block copies the settings at that moment. It drives chip select low, runs the frame, and raises chip select again. When chip select rises, the received word appears right-aligned on `rxData`.

Top module: `spi_master_div`

## Requirements
- R1: While reset is applied and directly after it, csN is 1, busy is 0, sclk is 0, mosi is 0 and rxData is 0.
- R2: Each SCLK half period lasts (P/2)·(1+SCR) system clocks. P is the prescale value with bit 0 forced to 0, and any result below 2 is used as 2. SCR is an 8-bit value.
- R3: The control word holds SCR in bits 15:8, the phase in bit 7, the polarity in bit 6 and the size code in bits 3:0. Bits 31:16 and bits 5:4 have no effect on any output.
- R4: When no frame is running, sclk equals the polarity bit of the control word. It also sits at that level from chip select assertion until the first edge, and from the last edge until chip select rises.
- R5: With phase 0, mosi carries the first bit from the cycle in which csN falls. MISO is captured on SCLK edges 1, 3, 5 and so on. Mosi moves to the next bit on edges 2, 4 and so on.
- R6: With phase 1, MISO is captured on SCLK edges 2, 4 and so on. Mosi holds the first bit until edge 3, then moves on at each odd edge.
- R7: A frame has N bits and 2N SCLK edges. N is the size code plus 1 for codes 3 to 15, and N is 4 for codes 0 to 2. rxData changes only when csN rises, and then holds the N captured bits right-aligned with the upper bits zero.
- R8: A start accepted at a clock edge drives csN low and busy high at that edge. The first SCLK edge comes one half period later. csN rises and busy falls one half period after the last edge. busy always equals the inverse of csN.
- R9: The control word, prescale value and transmit word are sampled at the edge that accepts start. A start pulse or a change to these inputs while busy is high has no effect on the running frame.
- R10: mosi is 0 whenever busy is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctrlWord | input | 32 | Control word: SCR, phase, polarity, size code |
| prescale | input | 8 | Prescale value, bit 0 ignored |
| start | input | 1 | Starts a frame when sampled high while idle |
| txData | input | 16 | Word to send, right-aligned |
| rxData | output | 16 | Last received word, right-aligned, zero-extended |
| busy | output | 1 | High while a frame is in progress |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| csN | output | 1 | Active-low chip select |

## Verification
Two events can meet in one cycle. One is a start request, or a change to the control and prescale inputs. The other is the edge where a running frame shifts, captures or finishes. The bench provokes this by changing every setting and pulsing start in the middle of a frame. It then judges, cycle by cycle, that the frame completes with its original timing and data and that no second frame follows. It also checks that the idle SCLK level tracks the new polarity only after chip select has risen.

// File: rtl/spi_master_pkg.sv
package spi_master_pkg;
  localparam int CTRL_W    = 32;
  localparam int SCR_LSB   = 8;
  localparam int PHASE_BIT = 7;
  localparam int POL_BIT   = 6;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic load;
    logic capture;
    logic shift;
    logic finish;
  } spiStrobe_t;
endpackage

// File: rtl/spi_master_ctrl.sv
module spi_master_ctrl
  import spi_master_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int PRE_W  = 8,
  parameter int SCR_W  = 8,
  localparam int DSS_W = $clog2(DATA_W),
  localparam int CNT_W = $clog2(DATA_W + 1),
  localparam int EV_W  = $clog2(2 * DATA_W + 2)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [SCR_W-1:0] scrIn,
  input  logic             phaseIn,
  input  logic             polIn,
  input  logic [DSS_W-1:0] dssIn,
  input  logic [PRE_W-1:0] prescaleIn,
  input  logic             start,
  output spiStrobe_t       strobe,
  output logic [CNT_W-1:0] loadBits,
  output logic             busy,
  output logic             csN,
  output logic             sclk
);
  logic [PRE_W-2:0] livePreHalf, preHalfL, preCnt;
  logic [SCR_W-1:0] scrL, scrCnt;
  logic [CNT_W-1:0] nBitsL, capCnt;
  logic [EV_W-1:0]  evCnt, evNext, lastEdge;
  logic             phaseL, polL;
  logic             tick, halfEv, edgeEv, endEv, isCap;

  // even prescale halved, floor of one
  assign livePreHalf = (prescaleIn[PRE_W-1:1] == '0) ? (PRE_W-1)'(1)
                                                     : prescaleIn[PRE_W-1:1];
  assign loadBits = (dssIn < DSS_W'(3)) ? CNT_W'(4) : CNT_W'(dssIn) + CNT_W'(1);

  assign tick     = (preCnt == preHalfL - (PRE_W-1)'(1));
  assign halfEv   = busy && tick && (scrCnt == scrL);
  assign evNext   = evCnt + EV_W'(1);
  assign lastEdge = {EV_W'(nBitsL), 1'b0} >> 0;
  assign edgeEv   = halfEv && (evNext <= EV_W'(2) * EV_W'(nBitsL));
  assign endEv    = halfEv && (evNext > EV_W'(2) * EV_W'(nBitsL));
  assign isCap    = evNext[0] ^ phaseL;

  always_comb begin
    strobe.load    = !busy && start;
    strobe.capture = edgeEv && isCap;
    strobe.shift   = edgeEv && !isCap && (capCnt != '0) && (capCnt < nBitsL);
    strobe.finish  = endEv;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy <= 1'b0; csN <= 1'b1; sclk <= 1'b0;
      phaseL <= 1'b0; polL <= 1'b0; scrL <= '0; preHalfL <= '0; nBitsL <= '0;
      preCnt <= '0; scrCnt <= '0; evCnt <= '0; capCnt <= '0;
    end else if (!busy) begin
      sclk <= polIn;
      if (start) begin
        busy <= 1'b1; csN <= 1'b0;
        phaseL <= phaseIn; polL <= polIn; scrL <= scrIn;
        preHalfL <= livePreHalf; nBitsL <= loadBits;
        preCnt <= '0; scrCnt <= '0; evCnt <= '0; capCnt <= '0;
      end
    end else begin
      if (tick) begin
        preCnt <= '0;
        scrCnt <= (scrCnt == scrL) ? '0 : scrCnt + SCR_W'(1);
      end else begin
        preCnt <= preCnt + (PRE_W-1)'(1);
      end
      if (halfEv) evCnt <= evNext;
      if (edgeEv) sclk <= ~sclk;
      if (strobe.capture) capCnt <= capCnt + CNT_W'(1);
      if (endEv) begin
        busy <= 1'b0; csN <= 1'b1; sclk <= polL;
      end
    end
  end

  logic unusedLast;
  assign unusedLast = ^lastEdge;
endmodule

// File: rtl/spi_master_dp.sv
module spi_master_dp
  import spi_master_pkg::*;
#(
  parameter int DATA_W = 16,
  localparam int CNT_W = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  spiStrobe_t        strobe,
  input  logic [CNT_W-1:0]  loadBits,
  input  logic [DATA_W-1:0] txData,
  input  logic              miso,
  input  logic              busy,
  output logic              mosi,
  output logic [DATA_W-1:0] rxData
);
  logic [DATA_W-1:0] txShift, rxShift;
  logic [CNT_W-1:0]  alignAmt;

  assign alignAmt = CNT_W'(DATA_W) - loadBits;
  assign mosi     = busy & txShift[DATA_W-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txShift <= '0; rxShift <= '0; rxData <= '0;
    end else begin
      if (strobe.load) begin
        txShift <= txData << alignAmt;
        rxShift <= '0;
      end
      if (strobe.shift)   txShift <= {txShift[DATA_W-2:0], 1'b0};
      if (strobe.capture) rxShift <= {rxShift[DATA_W-2:0], miso};
      if (strobe.finish)  rxData  <= rxShift;
    end
  end
endmodule

// File: rtl/spi_master_div.sv
module spi_master_div
  import spi_master_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int PRE_W  = 8,
  parameter int SCR_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CTRL_W-1:0] ctrlWord,
  input  logic [PRE_W-1:0]  prescale,
  input  logic              start,
  input  logic [DATA_W-1:0] txData,
  output logic [DATA_W-1:0] rxData,
  output logic              busy,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic              csN
);
  localparam int DSS_W = $clog2(DATA_W);
  localparam int CNT_W = $clog2(DATA_W + 1);

  spiStrobe_t       strobe;
  logic [CNT_W-1:0] loadBits;
  logic             unusedBits;

  assign unusedBits = ^{ctrlWord[CTRL_W-1:SCR_LSB+SCR_W], ctrlWord[POL_BIT-1:DSS_W]};

  spi_master_ctrl #(.DATA_W(DATA_W), .PRE_W(PRE_W), .SCR_W(SCR_W)) ctrl_i (
    .clk(clk), .rstN(rstN),
    .scrIn(ctrlWord[SCR_LSB +: SCR_W]),
    .phaseIn(ctrlWord[PHASE_BIT]), .polIn(ctrlWord[POL_BIT]),
    .dssIn(ctrlWord[DSS_W-1:0]), .prescaleIn(prescale), .start(start),
    .strobe(strobe), .loadBits(loadBits), .busy(busy), .csN(csN), .sclk(sclk)
  );

  spi_master_dp #(.DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .loadBits(loadBits),
    .txData(txData), .miso(miso), .busy(busy), .mosi(mosi), .rxData(rxData)
  );
endmodule

// File: rtl/spi_master_div_chk.sv
module spi_master_div_chk
  import spi_master_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic [CTRL_W-1:0] ctrlWord,
  input logic              busy,
  input logic              csN,
  input logic              sclk,
  input logic              mosi,
  input logic [DATA_W-1:0] rxData
);
  logic armed;
  always_ff @(posedge clk) begin
    if (!rstN) armed <= 1'b0;
    else       armed <= 1'b1;
  end

  a_r8_cs_tracks_busy: assert property (@(posedge clk) disable iff (!rstN)
    csN == !busy);

  a_r10_mosi_idle_low: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !mosi);

  a_r4_idle_level: assert property (@(posedge clk) disable iff (!rstN)
    (armed && !busy && !$past(busy)) |-> (sclk == $past(ctrlWord[POL_BIT])));

  a_r7_rx_holds_in_frame: assert property (@(posedge clk) disable iff (!rstN)
    (armed && busy && $past(busy)) |-> $stable(rxData));
endmodule

bind spi_master_div spi_master_div_chk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rstN(rstN), .ctrlWord(ctrlWord), .busy(busy), .csN(csN),
  .sclk(sclk), .mosi(mosi), .rxData(rxData)
);

// File: tb/spi_master_div_tb_top.sv
`timescale 1ns/1ps
module spi_master_div_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] ctrlWord = '0;
  logic [7:0]  prescale = '0;
  logic        start = 1'b0;
  logic [15:0] txData = '0;
  logic [15:0] rxData;
  logic        busy, sclk, mosi, csN;
  logic        miso = 1'b0;

  int compared = 0;
  int mismatched = 0;

  always #2.5 clk = ~clk;

  spi_master_div dut_i (
    .clk(clk), .rstN(rstN), .ctrlWord(ctrlWord), .prescale(prescale),
    .start(start), .txData(txData), .rxData(rxData), .busy(busy),
    .sclk(sclk), .mosi(mosi), .miso(miso), .csN(csN)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
    end
  endtask

  // behavioural reference state
  bit          inFrame = 0;
  int          e, hp, n, k, s;
  logic        mCpol, mCpha;
  logic [15:0] mTx, mRx, expRx = '0, rxPatIn = '0;

  task automatic step();
    logic eS, eB, eC, eM;
    string mt;
    int p;
    if (!inFrame && start) begin
      inFrame = 1; e = 0;
      mCpol = ctrlWord[6]; mCpha = ctrlWord[7];
      p = prescale & 8'hFE;
      if (p < 2) p = 2;
      hp = (p / 2) * (ctrlWord[15:8] + 1);
      n = (ctrlWord[3:0] < 3) ? 4 : ctrlWord[3:0] + 1;
      mTx = txData; mRx = rxPatIn;
    end else if (inFrame) e++;
    if (inFrame) begin
      k = e / hp;
      if (k >= 2 * n + 1) begin
        inFrame = 0;
        expRx = mRx & 16'((1 << n) - 1);
        eS = mCpol; eB = 0; eC = 1; eM = 0; mt = "R10";
      end else begin
        eB = 1; eC = 0; eS = mCpol ^ k[0];
        if (!mCpha) s = (k / 2 < n - 1) ? k / 2 : n - 1;
        else        s = (k < 3) ? 0 : (((k - 1) / 2 < n - 1) ? (k - 1) / 2 : n - 1);
        eM = mTx[n-1-s];
        miso = mRx[n-1-s];
        mt = mCpha ? "R6" : "R5";
      end
    end else begin
      eS = ctrlWord[6]; eB = 0; eC = 1; eM = 0; mt = "R10";
    end
    chk("R8 busy", {15'd0, busy}, {15'd0, eB});
    chk("R8 csN", {15'd0, csN}, {15'd0, eC});
    chk(inFrame ? "R2 sclk" : "R4 sclk", {15'd0, sclk}, {15'd0, eS});
    chk({mt, " mosi"}, {15'd0, mosi}, {15'd0, eM});
    chk("R7 rxData", rxData, expRx);
  endtask

  always @(posedge clk) begin
    #1;
    if (rstN) step();
  end

  task automatic endCheck(input string tag, input logic [31:0] c, input logic [15:0] r);
    int nb;
    nb = (c[3:0] < 3) ? 4 : c[3:0] + 1;
    chk(tag, rxData, r & 16'((1 << nb) - 1));
  endtask

  task automatic runFrame(input logic [31:0] c, input logic [7:0] p,
                          input logic [15:0] t, input logic [15:0] r, input string tag);
    @(negedge clk);
    ctrlWord = c; prescale = p; txData = t; rxPatIn = r; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait (!inFrame);
    repeat (2) @(negedge clk);
    endCheck(tag, c, r);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL R8 watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [31:0] c1;
    repeat (2) @(negedge clk);
    // R1: outputs under reset
    chk("R1 csN", {15'd0, csN}, 16'd1);
    chk("R1 busy", {15'd0, busy}, 16'd0);
    chk("R1 sclk", {15'd0, sclk}, 16'd0);
    chk("R1 mosi", {15'd0, mosi}, 16'd0);
    chk("R1 rxData", rxData, 16'd0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    // mode 0, SCR 1, 8 bits
    runFrame(32'h0000_0107, 8'd2, 16'h00A5, 16'h003C, "R5 rx mode0");
    // mode 1, prescale 4
    runFrame(32'h0000_0087, 8'd4, 16'h005A, 16'h00C3, "R6 rx mode1");
    // mode 2, 16 bits
    runFrame(32'h0000_004F, 8'd2, 16'hBEEF, 16'h1234, "R4 rx mode2");
    // mode 3, prescale 6 SCR 2, 12 bits
    runFrame(32'h0000_02CB, 8'd6, 16'h0ABC, 16'hF5A6, "R6 rx mode3");
    // prescale 0 clamps to 2, size code 0 gives 4 bits
    runFrame(32'h0000_0200, 8'd0, 16'hFFF9, 16'hFFF6, "R7 rx small code");
    // prescale 3 acts as 2, 4 bits
    runFrame(32'h0000_0003, 8'd3, 16'h000C, 16'h0005, "R2 rx odd prescale");
    // reserved and format bits set
    runFrame(32'hDEAD_0137, 8'd2, 16'h0096, 16'h0069, "R3 rx reserved bits");
    // R9: settings change and start during a frame
    c1 = 32'h0000_0047;
    @(negedge clk);
    ctrlWord = c1; prescale = 8'd2; txData = 16'h0033; rxPatIn = 16'h00E1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (10) @(negedge clk);
    ctrlWord = 32'h0000_0380; prescale = 8'd8; txData = 16'hFFFF; rxPatIn = 16'h0000;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait (!inFrame);
    repeat (3) @(negedge clk);
    endCheck("R9 rx latched", c1, 16'h00E1);
    chk("R9 no second frame", {15'd0, busy}, 16'd0);
    repeat (4) @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule